// File: doc/BRIEF.md
# I2C Master Message Sequencer

This block is the upper layer of a single-master I2C controller. It takes a transfer request naming one 7-bit target and a count of messages. It then pulls message descriptors one at a time; each carries a direction, a byte length, a restart flag and a stop flag. The block turns this list into a stream of bus commands for a separate bit-level engine: release SCL, START, repeated START, STOP, write one bit and read one bit. It shifts address and data bytes out MSB first and checks every acknowledge bit. It assembles received bytes and acknowledges each one. Write bytes arrive on a ready/valid byte stream, and read bytes leave as single-cycle pulses.

The bit engine owns all bus timing. The sequencer holds each command steady until the engine reports that it is complete, and the engine returns the sampled SDA level with read-bit commands. Every transfer opens by releasing SCL and issuing STOP followed by START, and it ends with one STOP whatever the outcome. After that STOP a status pulse gives success, or an error if any acknowledge was missing. A small combinational check flags bus configurations the sequencer cannot serve.

Top module: `i2c_msg_seq`

## Requirements
- R1: A request with a message count of zero raises `xfer_done` with `xfer_ok`=1 on the next cycle, issues no bus command and never raises `busy`.
- R2: Command codes on `cmd_op` are 0 release SCL, 1 START, 2 repeated START, 3 STOP, 4 write bit (`cmd_bit` carries the level), 5 read bit (`cmd_rbit` returns the level). A transfer with messages starts with 0, then 3, then 1, followed by the first message's address byte.
- R3: When the message just finished had its stop flag set and more messages remain, the sequencer issues STOP, then START, then the next message's address byte.
- R4: When the finished message had no stop flag and the next message has its restart flag, a repeated START and an address byte follow. When neither flag is set, the next message's data continues directly, with no bus condition and no address.
- R5: The address byte is the 7-bit target followed by a direction bit in bit 0, with 1 meaning read. It is sent like any written byte.
- R6: A written byte is issued as eight write-bit commands, MSB first, followed by one read-bit command for the acknowledge, where 0 means ACK. Write bytes are taken from the write stream only when needed, one per data byte.
- R7: A read level of 1 on the acknowledge of an address or write byte ends the transfer at once. The sequencer issues STOP, reports `xfer_ok`=0, and takes no further messages or write bytes.
- R8: A read byte is built MSB first from eight read-bit commands and is output with a one-cycle `rd_valid` pulse. It is then followed by a write-bit command carrying 0, or 1 for the last byte of the message.
- R9: Every transfer with messages ends with a STOP command. `xfer_done` pulses in the cycle after that STOP completes, and `busy` is low in that same cycle. `busy` is high from the cycle after acceptance until then.
- R10: `cfg_unsupported` is 1 when 10-bit addressing is requested, or when `cfg_speed` is neither 1 (standard) nor 2 (fast).
- R11: A message of length zero sends only its address byte, and only when a START or repeated START comes before it. It then moves on to the next message.
- R12: A command on the engine interface keeps `cmd_valid`, `cmd_op` and `cmd_bit` unchanged until a cycle in which `cmd_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ten_bit | input | 1 | Configuration asks for 10-bit addressing |
| cfg_speed | input | 2 | Requested bus speed code (1 standard, 2 fast) |
| cfg_unsupported | output | 1 | Requested configuration cannot be served |
| xfer_start | input | 1 | Start a transfer (accepted while idle) |
| xfer_addr | input | 7 | Target address |
| xfer_nmsg | input | 4 | Number of messages in the list |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_ok | output | 1 | Success flag, valid with `xfer_done` |
| msg_valid | input | 1 | Message descriptor available |
| msg_ready | output | 1 | Sequencer takes the descriptor |
| msg_read | input | 1 | Message direction, 1 = read |
| msg_restart | input | 1 | Message asks for a repeated START |
| msg_stop | input | 1 | STOP after this message |
| msg_len | input | 8 | Message length in bytes |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Sequencer takes the write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte pulse |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Bus command pending |
| cmd_op | output | 3 | Bus command code |
| cmd_bit | output | 1 | Level for a write-bit command |
| cmd_done | input | 1 | Engine completed the pending command |
| cmd_rbit | input | 1 | Sampled SDA level for a read-bit command |

## Verification
The checker watches, on every cycle, the properties that need no history of the message list. These are the command hold rule, the quiet engine interface while idle, release-SCL as the first command of a busy period, a completion pulse only after a STOP (or straight after a zero-count request), an acknowledge write after every read byte, and no overlap between taking stream data and issuing commands. The ordering of conditions between messages, the address and direction bits, the MSB-first byte order, NACK aborts and the treatment of zero-length messages depend on the whole list. Only the directed scenarios can show these, and they do it by comparing the full logged command sequence and the received bytes against sequences built in the bench.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        OP_RELEASE = 3'd0,
        OP_START   = 3'd1,
        OP_RSTART  = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRBIT   = 3'd4,
        OP_RDBIT   = 3'd5
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REL,
        ST_STOP,
        ST_START,
        ST_GETMSG,
        ST_DATA,
        ST_WFETCH,
        ST_WBITS,
        ST_ACKR,
        ST_RBITS,
        ST_ACKW,
        ST_FIN
    } seq_st_e;

    localparam logic [1:0] SPD_STANDARD = 2'd1;
    localparam logic [1:0] SPD_FAST     = 2'd2;

endpackage

// File: rtl/i2c_seq_cfg_check.sv
module i2c_seq_cfg_check
    import i2c_seq_pkg::*;
(
    input  logic       ten_bit,
    input  logic [1:0] speed,
    output logic       unsupported
);
    logic speed_ok;

    always_comb begin
        speed_ok    = (speed == SPD_STANDARD) || (speed == SPD_FAST);
        unsupported = ten_bit || !speed_ok;
    end
endmodule

// File: rtl/i2c_seq_shifter.sv
module i2c_seq_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] q,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  q_d, q_q;
    logic [CW-1:0] c_d, c_q;

    always_comb begin
        q_d = q_q;
        c_d = c_q;
        if (load) begin
            q_d = load_val;
            c_d = '0;
        end else if (shift) begin
            q_d = {q_q[W-2:0], in_bit};
            c_d = c_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
            c_q <= '0;
        end else begin
            q_q <= q_d;
            c_q <= c_d;
        end
    end

    assign q    = q_q;
    assign last = (c_q == CW'(W - 1));
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_seq_pkg::*;
#(
    parameter int AW = 7,
    parameter int NW = 4,
    parameter int LW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ten_bit,
    input  logic [1:0]    cfg_speed,
    output logic          cfg_unsupported,
    input  logic          xfer_start,
    input  logic [AW-1:0] xfer_addr,
    input  logic [NW-1:0] xfer_nmsg,
    output logic          busy,
    output logic          xfer_done,
    output logic          xfer_ok,
    input  logic          msg_valid,
    output logic          msg_ready,
    input  logic          msg_read,
    input  logic          msg_restart,
    input  logic          msg_stop,
    input  logic [LW-1:0] msg_len,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          cmd_valid,
    output logic [2:0]    cmd_op,
    output logic          cmd_bit,
    input  logic          cmd_done,
    input  logic          cmd_rbit
);
    localparam int ABW = AW + 1;

    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] addr;
        logic [NW-1:0] msgs;
        logic [LW-1:0] bytes;
        logic          rd;
        logic          stp;
        logic          rs;
        logic          apend;
        logic          isaddr;
        logic          err;
        logic          done;
        logic          ok;
        logic          rdv;
    } seq_t;

    seq_t          r_q, r_d;
    bus_op_e       op;
    logic          sh_load, sh_shift, sh_in, sh_last;
    logic [DW-1:0] sh_val, sh_q;

    i2c_seq_cfg_check u_cfg (
        .ten_bit     (cfg_ten_bit),
        .speed       (cfg_speed),
        .unsupported (cfg_unsupported)
    );

    i2c_seq_shifter #(.W(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .in_bit   (sh_in),
        .q        (sh_q),
        .last     (sh_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.rdv   = 1'b0;
        sh_load   = 1'b0;
        sh_val    = '0;
        sh_shift  = 1'b0;
        sh_in     = 1'b0;
        msg_ready = 1'b0;
        wr_ready  = 1'b0;
        cmd_valid = 1'b0;
        op        = OP_RELEASE;
        cmd_bit   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    r_d.addr = xfer_addr;
                    r_d.err  = 1'b0;
                    if (xfer_nmsg == '0) begin
                        r_d.done = 1'b1;
                        r_d.ok   = 1'b1;
                    end else begin
                        r_d.msgs = xfer_nmsg;
                        r_d.st   = ST_REL;
                    end
                end
            end
            ST_REL: begin
                cmd_valid = 1'b1;
                op        = OP_RELEASE;
                if (cmd_done) r_d.st = ST_STOP;
            end
            ST_STOP: begin
                cmd_valid = 1'b1;
                op        = OP_STOP;
                if (cmd_done) begin
                    r_d.st = ST_START;
                    r_d.rs = 1'b0;
                end
            end
            ST_START: begin
                cmd_valid = 1'b1;
                op        = r_q.rs ? OP_RSTART : OP_START;
                if (cmd_done) begin
                    if (r_q.rs) begin
                        r_d.st = ST_WBITS;
                    end else begin
                        r_d.st    = ST_GETMSG;
                        r_d.apend = 1'b1;
                    end
                end
            end
            ST_GETMSG: begin
                msg_ready = 1'b1;
                if (msg_valid) begin
                    r_d.rd     = msg_read;
                    r_d.bytes  = msg_len;
                    r_d.stp    = msg_stop;
                    r_d.isaddr = 1'b1;
                    sh_load    = 1'b1;
                    sh_val     = DW'(ABW'({r_q.addr, msg_read}));
                    if (r_q.apend) begin
                        r_d.apend = 1'b0;
                        r_d.st    = ST_WBITS;
                    end else if (msg_restart) begin
                        r_d.rs = 1'b1;
                        r_d.st = ST_START;
                    end else begin
                        r_d.isaddr = 1'b0;
                        r_d.st     = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (r_q.bytes == '0) begin
                    if (r_q.msgs == NW'(1)) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.msgs = r_q.msgs - 1'b1;
                        r_d.st   = r_q.stp ? ST_STOP : ST_GETMSG;
                    end
                end else if (r_q.rd) begin
                    sh_load = 1'b1;
                    r_d.st  = ST_RBITS;
                end else begin
                    r_d.st = ST_WFETCH;
                end
            end
            ST_WFETCH: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    sh_load    = 1'b1;
                    sh_val     = wr_data;
                    r_d.isaddr = 1'b0;
                    r_d.st     = ST_WBITS;
                end
            end
            ST_WBITS: begin
                cmd_valid = 1'b1;
                op        = OP_WRBIT;
                cmd_bit   = sh_q[DW-1];
                if (cmd_done) begin
                    sh_shift = 1'b1;
                    if (sh_last) r_d.st = ST_ACKR;
                end
            end
            ST_ACKR: begin
                cmd_valid = 1'b1;
                op        = OP_RDBIT;
                if (cmd_done) begin
                    if (cmd_rbit) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_FIN;
                    end else begin
                        if (!r_q.isaddr) r_d.bytes = r_q.bytes - 1'b1;
                        r_d.isaddr = 1'b0;
                        r_d.st     = ST_DATA;
                    end
                end
            end
            ST_RBITS: begin
                cmd_valid = 1'b1;
                op        = OP_RDBIT;
                if (cmd_done) begin
                    sh_shift = 1'b1;
                    sh_in    = cmd_rbit;
                    if (sh_last) begin
                        r_d.bytes = r_q.bytes - 1'b1;
                        r_d.rdv   = 1'b1;
                        r_d.st    = ST_ACKW;
                    end
                end
            end
            ST_ACKW: begin
                cmd_valid = 1'b1;
                op        = OP_WRBIT;
                cmd_bit   = (r_q.bytes == '0);
                if (cmd_done) r_d.st = ST_DATA;
            end
            ST_FIN: begin
                cmd_valid = 1'b1;
                op        = OP_STOP;
                if (cmd_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.ok   = !r_q.err;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_op    = op;
    assign busy      = (r_q.st != ST_IDLE);
    assign xfer_done = r_q.done;
    assign xfer_ok   = r_q.ok;
    assign rd_valid  = r_q.rdv;
    assign rd_data   = sh_q;
endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk
    import i2c_seq_pkg::*;
#(
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_start,
    input logic [NW-1:0] xfer_nmsg,
    input logic          busy,
    input logic          xfer_done,
    input logic          xfer_ok,
    input logic          msg_ready,
    input logic          wr_ready,
    input logic          rd_valid,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          cmd_bit,
    input logic          cmd_done
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    a_r1_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !busy && xfer_nmsg == '0) |=> (xfer_done && xfer_ok && !busy));

    a_r2_first_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cmd_valid && cmd_op == 3'(OP_RELEASE)));

    a_r9_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!busy && ($past(cmd_valid && cmd_done && cmd_op == 3'(OP_STOP))
                                 || $past(xfer_start && xfer_nmsg == '0))));

    a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bit)));

    a_r8_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (cmd_valid && cmd_op == 3'(OP_WRBIT)));

    a_r6_fetch_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready || msg_ready) |-> (!cmd_valid && !(wr_ready && msg_ready)));
endmodule

bind i2c_msg_seq i2c_msg_seq_chk #(.NW(NW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_nmsg  (xfer_nmsg),
    .busy       (busy),
    .xfer_done  (xfer_done),
    .xfer_ok    (xfer_ok),
    .msg_ready  (msg_ready),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bit    (cmd_bit),
    .cmd_done   (cmd_done)
);

// File: tb/i2c_msg_seq_bench.sv
module i2c_msg_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ten_bit = 1'b0;
    logic [1:0] cfg_speed = 2'd1;
    logic       cfg_unsupported;
    logic       xfer_start = 1'b0;
    logic [6:0] xfer_addr = '0;
    logic [3:0] xfer_nmsg = '0;
    logic       busy, xfer_done, xfer_ok;
    logic       msg_valid = 1'b0;
    logic       msg_ready;
    logic       msg_read = 1'b0, msg_restart = 1'b0, msg_stop = 1'b0;
    logic [7:0] msg_len = '0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_data = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic       cmd_bit;
    logic       cmd_done = 1'b0;
    logic       cmd_rbit = 1'b0;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int unstable = 0;

    logic [7:0]  wq[$];
    logic [10:0] mq[$];
    logic        rq[$];
    int          log_q[$];
    int          exq[$];
    logic [7:0]  rdq[$];

    always #5 clk = ~clk;

    i2c_msg_seq u_i2c_msg_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_ten_bit(cfg_ten_bit), .cfg_speed(cfg_speed), .cfg_unsupported(cfg_unsupported),
        .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_nmsg(xfer_nmsg),
        .busy(busy), .xfer_done(xfer_done), .xfer_ok(xfer_ok),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_read(msg_read),
        .msg_restart(msg_restart), .msg_stop(msg_stop), .msg_len(msg_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
        .cmd_done(cmd_done), .cmd_rbit(cmd_rbit)
    );

    // Bit engine, stream sources and read sink, all updated at the falling edge.
    initial begin
        bit       eng_busy = 0;
        int       wcnt = 0;
        bit       wtook = 0;
        bit       mtook = 0;
        logic [2:0] h_op = '0;
        logic       h_bit = 1'b0;
        forever begin
            @(negedge clk);
            if (cmd_done) begin
                cmd_done = 1'b0;
                cmd_rbit = 1'b0;
            end else if (cmd_valid) begin
                if (!eng_busy) begin
                    eng_busy = 1;
                    h_op = cmd_op;
                    h_bit = cmd_bit;
                    wcnt = lat;
                end else if (cmd_op != h_op || cmd_bit != h_bit) begin
                    unstable++;
                end
                if (wcnt == 0) begin
                    eng_busy = 0;
                    cmd_done = 1'b1;
                    log_q.push_back(int'(cmd_op) * 2 + ((cmd_op == 3'd4) ? int'(cmd_bit) : 0));
                    if (cmd_op == 3'd5 && rq.size() > 0) cmd_rbit = rq.pop_front();
                    else cmd_rbit = 1'b0;
                end else begin
                    wcnt--;
                end
            end
            if (rd_valid) rdq.push_back(rd_data);
            if (wtook && wq.size() > 0) void'(wq.pop_front());
            wr_valid = (wq.size() > 0);
            wr_data  = wr_valid ? wq[0] : 8'h00;
            wtook    = wr_valid && wr_ready;
            if (mtook && mq.size() > 0) void'(mq.pop_front());
            msg_valid = (mq.size() > 0);
            {msg_read, msg_restart, msg_stop, msg_len} = msg_valid ? mq[0] : 11'h0;
            mtook = msg_valid && msg_ready;
        end
    end

    task automatic chk(input bit c, input string req, input int act, input int exp);
        checks++;
        if (!c) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic e(input int op, input int b);
        exq.push_back(op * 2 + ((op == 4) ? b : 0));
    endtask

    task automatic ebyte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) e(4, int'(b[i]));
    endtask

    task automatic erd8();
        for (int i = 0; i < 8; i++) e(5, 0);
    endtask

    task automatic rpush(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) rq.push_back(b[i]);
    endtask

    task automatic msg(input bit rd, input bit rs, input bit st, input int len);
        mq.push_back({rd, rs, st, 8'(len)});
    endtask

    task automatic clear_all();
        wq.delete(); mq.delete(); rq.delete();
        log_q.delete(); exq.delete(); rdq.delete();
        unstable = 0;
    endtask

    task automatic cmp_log(input string req);
        int idx = -1;
        int n = (log_q.size() < exq.size()) ? log_q.size() : exq.size();
        chk(log_q.size() == exq.size(), {req, " command count"}, log_q.size(), exq.size());
        for (int i = 0; i < n; i++) begin
            if (idx < 0 && log_q[i] != exq[i]) idx = i;
        end
        if (idx < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, {req, " command entry"}, log_q[idx], exq[idx]);
    endtask

    task automatic run(input logic [6:0] a, input int n, output bit ok, output bit seen_busy);
        int k = 0;
        @(negedge clk);
        xfer_addr  = a;
        xfer_nmsg  = 4'(n);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        seen_busy  = busy;
        while (!xfer_done && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(xfer_done, "R9 completion pulse", int'(xfer_done), 1);
        chk(!busy, "R9 busy low at completion", int'(busy), 0);
        ok = xfer_ok;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !cmd_valid && !xfer_done && !rd_valid, "R9 reset state idle",
            int'({busy, cmd_valid, xfer_done, rd_valid}), 0);
    endtask

    task automatic t_zero();
        bit ok, sb;
        clear_all();
        run(7'h50, 0, ok, sb);
        chk(ok, "R1 zero messages ok", int'(ok), 1);
        chk(!sb, "R1 zero messages busy", int'(sb), 0);
        chk(log_q.size() == 0, "R1 zero messages no commands", log_q.size(), 0);
    endtask

    task automatic t_write();
        bit ok, sb;
        clear_all();
        lat = 2;
        msg(0, 0, 1, 2);
        wq.push_back(8'hA5); wq.push_back(8'h3C);
        e(0, 0); e(3, 0); e(1, 0);
        ebyte(8'hA0); e(5, 0); ebyte(8'hA5); e(5, 0); ebyte(8'h3C); e(5, 0); e(3, 0);
        run(7'h50, 1, ok, sb);
        cmp_log("R2 R5 R6 write message");
        chk(ok, "R6 write ok", int'(ok), 1);
        chk(sb, "R9 busy during transfer", int'(sb), 1);
        chk(unstable == 0, "R12 command held while engine waits", unstable, 0);
        chk(wq.size() == 0, "R6 both write bytes taken", wq.size(), 0);
        lat = 0;
    endtask

    task automatic t_read_rs();
        bit ok, sb;
        clear_all();
        msg(0, 0, 0, 1);
        msg(1, 1, 0, 2);
        wq.push_back(8'h12);
        rq.push_back(1'b0); rq.push_back(1'b0); rq.push_back(1'b0);
        rpush(8'hC3); rpush(8'h5A);
        e(0, 0); e(3, 0); e(1, 0);
        ebyte(8'hA0); e(5, 0); ebyte(8'h12); e(5, 0);
        e(2, 0); ebyte(8'hA1); e(5, 0);
        erd8(); e(4, 0); erd8(); e(4, 1); e(3, 0);
        run(7'h50, 2, ok, sb);
        cmp_log("R4 R8 restart then read");
        chk(ok, "R8 read ok", int'(ok), 1);
        chk(rdq.size() == 2, "R8 read byte count", rdq.size(), 2);
        if (rdq.size() == 2) begin
            chk(rdq[0] == 8'hC3, "R8 first read byte", int'(rdq[0]), 'hC3);
            chk(rdq[1] == 8'h5A, "R8 second read byte", int'(rdq[1]), 'h5A);
        end
    endtask

    task automatic t_stop_between();
        bit ok, sb;
        clear_all();
        msg(0, 0, 1, 1);
        msg(0, 0, 0, 1);
        wq.push_back(8'h11); wq.push_back(8'h22);
        e(0, 0); e(3, 0); e(1, 0);
        ebyte(8'hA0); e(5, 0); ebyte(8'h11); e(5, 0);
        e(3, 0); e(1, 0);
        ebyte(8'hA0); e(5, 0); ebyte(8'h22); e(5, 0); e(3, 0);
        run(7'h50, 2, ok, sb);
        cmp_log("R3 stop then start between messages");
        chk(ok, "R3 ok", int'(ok), 1);
    endtask

    task automatic t_noaddr();
        bit ok, sb;
        clear_all();
        msg(0, 0, 0, 1);
        msg(0, 0, 0, 1);
        wq.push_back(8'h81); wq.push_back(8'h7E);
        e(0, 0); e(3, 0); e(1, 0);
        ebyte(8'h56); e(5, 0); ebyte(8'h81); e(5, 0); ebyte(8'h7E); e(5, 0); e(3, 0);
        run(7'h2B, 2, ok, sb);
        cmp_log("R4 data continues without address");
        chk(ok, "R4 ok", int'(ok), 1);
    endtask

    task automatic t_zero_len();
        bit ok, sb;
        clear_all();
        msg(1, 0, 0, 0);
        msg(0, 0, 0, 0);
        wq.push_back(8'h99);
        e(0, 0); e(3, 0); e(1, 0);
        ebyte(8'hA1); e(5, 0); e(3, 0);
        run(7'h50, 2, ok, sb);
        cmp_log("R11 zero-length messages");
        chk(ok, "R11 ok", int'(ok), 1);
        chk(rdq.size() == 0, "R11 no read bytes", rdq.size(), 0);
        chk(wq.size() == 1, "R11 write byte untouched", wq.size(), 1);
    endtask

    task automatic t_nack_addr();
        bit ok, sb;
        clear_all();
        msg(0, 0, 0, 1);
        msg(0, 0, 0, 1);
        wq.push_back(8'h77);
        rq.push_back(1'b1);
        e(0, 0); e(3, 0); e(1, 0);
        ebyte(8'hA0); e(5, 0); e(3, 0);
        run(7'h50, 2, ok, sb);
        cmp_log("R7 address NACK");
        chk(!ok, "R7 address NACK error", int'(ok), 0);
        chk(wq.size() == 1, "R7 write byte not taken", wq.size(), 1);
        chk(mq.size() == 1, "R7 second message not taken", mq.size(), 1);
    endtask

    task automatic t_nack_data();
        bit ok, sb;
        clear_all();
        msg(0, 0, 0, 3);
        wq.push_back(8'h01); wq.push_back(8'h02); wq.push_back(8'h03);
        rq.push_back(1'b0); rq.push_back(1'b0); rq.push_back(1'b1);
        e(0, 0); e(3, 0); e(1, 0);
        ebyte(8'hA0); e(5, 0); ebyte(8'h01); e(5, 0); ebyte(8'h02); e(5, 0); e(3, 0);
        run(7'h50, 1, ok, sb);
        cmp_log("R7 data NACK");
        chk(!ok, "R7 data NACK error", int'(ok), 0);
        chk(wq.size() == 1, "R7 third byte not taken", wq.size(), 1);
    endtask

    task automatic t_cfg();
        for (int tb = 0; tb < 2; tb++) begin
            for (int sp = 0; sp < 4; sp++) begin
                bit exp = (tb == 1) || !(sp == 1 || sp == 2);
                cfg_ten_bit = 1'(tb);
                cfg_speed   = 2'(sp);
                #1;
                chk(cfg_unsupported == exp, "R10 configuration check", int'(cfg_unsupported), int'(exp));
            end
        end
        cfg_ten_bit = 1'b0;
        cfg_speed   = 2'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_write();
        t_read_rs();
        t_stop_between();
        t_noaddr();
        t_zero_len();
        t_nack_addr();
        t_nack_data();
        t_cfg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule